// File: doc/BRIEF.md
# Taylor-Refined Lookup Complex-Gain Predistorter

This block applies a memoryless complex-gain predistortion to a baseband I/Q sample stream. For every sample it forms the instantaneous power I² + Q². It cuts a fixed-point window out of that power and splits it into a coarse grid index and a fine fractional offset. The grid index selects three complex coefficient tables: the gain at the grid point, the slope of the gain there, and its curvature. A second-order Taylor expansion in the fractional offset refines the gain between grid points. The refined complex gain then multiplies the input sample.

The fractional offset is squared by a small constant square table rather than by a multiplier. The one-half weight on the curvature term costs nothing, because it is one extra bit of right shift. The three coefficient tables are loaded through a plain write port, typically by an adaptation engine outside this block. Both streams use valid/ready. An input sample transfers on a rising edge when `in_valid` and `in_ready` are both high, and an output sample when `out_valid` and `out_ready` are both high. The four-stage pipeline advances as a whole, and only while its output register is empty or being drained. A downstream stall therefore stops the pipeline and deasserts `in_ready` in the same cycle. While the stall lasts the output holds.

Top module: `dpd_taylor_lut`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid` is 0 and `in_ready` is 1.
- R2: The power is p = I² + Q², with I and Q signed 16-bit values. The index is x = p >> 18 (logical shift). When x ≤ 4095, the table address is k = x[11:6] and the fractional offset is d = x[5:0].
- R3: When x > 4095, the address saturates to k = 63 and the offset is forced to d = 0.
- R4: Each gain component is g = sat16(round((G0·8192 + G1·d·128 + G2·d²) / 8192)). G0, G1 and G2 are the selected entries of tables 0, 1 and 2. d² comes from a 64-entry square table. Rounding adds 4096 and then shifts arithmetically right by 13. sat16 clamps the result to [-32768, 32767].
- R5: On a rising edge with `tbl_wr_en` high, `tbl_sel` picks the table: 0 for gain, 1 for slope, 2 for curvature. The entry at `tbl_addr` is written with `tbl_data`: real part in bits 31:16, imaginary part in bits 15:0. A write with `tbl_sel` = 3 changes no table.
- R6: A sample accepted at or after the edge of a table write uses the new entry.
- R7: The output is the complex product of the input and the gain. out_i = sat16((I·gr − Q·gi + 8192) >>> 14) and out_q = sat16((I·gi + Q·gr + 8192) >>> 14). The input samples are Q1.15 and the gains are Q2.14.
- R8: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, the output values hold. Samples leave in arrival order, and none is lost or duplicated.
- R9: Suppose a sample is accepted at an edge and `out_ready` stays high. The sample is then on the outputs, with `out_valid` high, directly after the third following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the valid pipeline |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block accepts an input sample this cycle |
| in_i | input | 16 | Input in-phase component, signed Q1.15 |
| in_q | input | 16 | Input quadrature component, signed Q1.15 |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream accepts the output sample |
| out_i | output | 16 | Predistorted in-phase component, signed |
| out_q | output | 16 | Predistorted quadrature component, signed |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_sel | input | 2 | Table select: 0 gain, 1 slope, 2 curvature, 3 none |
| tbl_addr | input | 6 | Table entry address |
| tbl_data | input | 32 | Complex entry, real in 31:16, imaginary in 15:0 |

## Verification
The bound checker watches the stream protocol on every clock. It checks that the output holds and `in_ready` falls while the output is stalled, that the output is empty after reset, that valid output data is never unknown, and that a sample accepted under open flow control comes out after the fixed pipeline depth. The arithmetic cannot be seen at the ports cycle by cycle. The index split, the saturation of high powers, the Taylor refinement, the rounding and clamping, and the ignored table select can only be shown by the bench's scenarios. These compare every output sample against an independent integer model across low-power, high-power, random-table and back-pressured traffic.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
  localparam int SMP_W   = 16;           // sample and gain component width
  localparam int IDX_W   = 6;            // table address bits of the power
  localparam int FRC_W   = 6;            // fractional bits of the power
  localparam int GAIN_FB = 14;           // fractional bits of a gain (Q2.14)
  localparam int PWR_SH  = 18;           // power bits dropped before the index window
  localparam int PWR_W   = 2 * SMP_W + 1;
  localparam int SQ_W    = 2 * FRC_W;
  localparam int WIDE_W  = 48;
  localparam int NTAB    = 3;

  typedef struct packed {
    logic signed [SMP_W-1:0] re;
    logic signed [SMP_W-1:0] im;
  } cplx_t;

  localparam logic signed [WIDE_W-1:0] SMAX = (WIDE_W'(1) <<< (SMP_W - 1)) - WIDE_W'(1);
  localparam logic signed [WIDE_W-1:0] SMIN = -SMAX - WIDE_W'(1);

  function automatic logic signed [SMP_W-1:0] sat_s(input logic signed [WIDE_W-1:0] v);
    if (v > SMAX)      return SMAX[SMP_W-1:0];
    else if (v < SMIN) return SMIN[SMP_W-1:0];
    else               return v[SMP_W-1:0];
  endfunction

  // round half up at bit position sh, then clamp
  function automatic logic signed [SMP_W-1:0] rnd_sat(input logic signed [WIDE_W-1:0] v,
                                                      input int sh);
    logic signed [WIDE_W-1:0] t;
    t = (v + (WIDE_W'(1) <<< (sh - 1))) >>> sh;
    return sat_s(t);
  endfunction
endpackage

// File: rtl/dpd_coef_bank.sv
module dpd_coef_bank
  import dpd_pkg::*;
#(
  parameter int AW = IDX_W,
  parameter int NT = NTAB
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [AW-1:0]     wr_addr,
  input  logic [2*SMP_W-1:0] wr_data,
  output cplx_t [NT-1:0]    rd_data
);
  localparam int DEPTH = 1 << AW;

  for (genvar t = 0; t < NT; t++) begin : g_tab
    logic [2*SMP_W-1:0] mem [DEPTH];
    logic [2*SMP_W-1:0] q;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_sel == 2'(t))) mem[wr_addr] <= wr_data;
      if (rd_en) q <= mem[rd_addr];
    end
    assign rd_data[t] = cplx_t'(q);
  end
endmodule

// File: rtl/dpd_sq_rom.sv
module dpd_sq_rom
  import dpd_pkg::*;
#(
  parameter int FW = FRC_W
) (
  input  logic            clk,
  input  logic            en,
  input  logic [FW-1:0]   addr,
  output logic [2*FW-1:0] sq
);
  localparam int DEPTH = 1 << FW;
  logic [2*FW-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign rom[g] = (2*FW)'(g * g);
  end

  always_ff @(posedge clk) begin
    if (en) sq <= rom[addr];
  end
endmodule

// File: rtl/dpd_gain_refine.sv
module dpd_gain_refine
  import dpd_pkg::*;
#(
  parameter int FW = FRC_W
) (
  input  cplx_t           g0,
  input  cplx_t           g1,
  input  cplx_t           g2,
  input  logic [FW-1:0]   frac,
  input  logic [2*FW-1:0] frac_sq,
  output cplx_t           gain
);
  localparam int ACC_SH = 2 * FW + 1;  // d^2 scale plus the half weight
  localparam int D_SH   = FW + 1;

  function automatic logic signed [SMP_W-1:0] taylor(input logic signed [SMP_W-1:0] a0,
                                                     input logic signed [SMP_W-1:0] a1,
                                                     input logic signed [SMP_W-1:0] a2,
                                                     input logic [FW-1:0]   d,
                                                     input logic [2*FW-1:0] dd);
    logic signed [WIDE_W-1:0] base, lin, quad;
    base = WIDE_W'(a0) <<< ACC_SH;
    lin  = (WIDE_W'(a1) * WIDE_W'(signed'({1'b0, d}))) <<< D_SH;
    quad = WIDE_W'(a2) * WIDE_W'(signed'({1'b0, dd}));
    return rnd_sat(base + lin + quad, ACC_SH);
  endfunction

  always_comb begin
    gain.re = taylor(g0.re, g1.re, g2.re, frac, frac_sq);
    gain.im = taylor(g0.im, g1.im, g2.im, frac, frac_sq);
  end
endmodule

// File: rtl/dpd_cmul.sv
module dpd_cmul
  import dpd_pkg::*;
#(
  parameter int FB = GAIN_FB
) (
  input  cplx_t x,
  input  cplx_t g,
  output cplx_t y
);
  logic signed [WIDE_W-1:0] pr, pi;
  always_comb begin
    pr = WIDE_W'(x.re) * WIDE_W'(g.re) - WIDE_W'(x.im) * WIDE_W'(g.im);
    pi = WIDE_W'(x.re) * WIDE_W'(g.im) + WIDE_W'(x.im) * WIDE_W'(g.re);
    y.re = rnd_sat(pr, FB);
    y.im = rnd_sat(pi, FB);
  end
endmodule

// File: rtl/dpd_taylor_lut.sv
module dpd_taylor_lut
  import dpd_pkg::*;
#(
  parameter int PSHIFT = PWR_SH
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [SMP_W-1:0] in_i,
  input  logic signed [SMP_W-1:0] in_q,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [SMP_W-1:0] out_i,
  output logic signed [SMP_W-1:0] out_q,
  input  logic                    tbl_wr_en,
  input  logic [1:0]              tbl_sel,
  input  logic [IDX_W-1:0]        tbl_addr,
  input  logic [2*SMP_W-1:0]      tbl_data
);
  localparam int WIN_W = IDX_W + FRC_W;
  localparam logic [PWR_W-1:0] WIN_MAX = PWR_W'((1 << WIN_W) - 1);

  logic adv;
  logic v1, v2, v3, v4;

  assign adv      = !v4 || out_ready;
  assign in_ready = adv;

  // stage 1: power
  cplx_t x1;
  logic [PWR_W-1:0] pw1;
  logic signed [2*SMP_W-1:0] sq_i, sq_q;
  assign sq_i = (2*SMP_W)'(in_i) * (2*SMP_W)'(in_i);
  assign sq_q = (2*SMP_W)'(in_q) * (2*SMP_W)'(in_q);

  always_ff @(posedge clk) begin
    if (adv) begin
      x1  <= '{re: in_i, im: in_q};
      pw1 <= PWR_W'($unsigned(sq_i)) + PWR_W'($unsigned(sq_q));
    end
  end

  // index split with saturation of the top window
  logic [PWR_W-1:0] win;
  logic             over;
  logic [IDX_W-1:0] k1;
  logic [FRC_W-1:0] d1;
  always_comb begin
    win  = pw1 >> PSHIFT;
    over = (win > WIN_MAX);
    k1   = over ? '1 : win[WIN_W-1:FRC_W];
    d1   = over ? '0 : win[FRC_W-1:0];
  end

  // stage 2: synchronous table reads
  cplx_t [NTAB-1:0] coef2;
  logic [SQ_W-1:0]  dsq2;
  logic [FRC_W-1:0] d2;
  cplx_t            x2;

  dpd_coef_bank #(.AW(IDX_W), .NT(NTAB)) u_bank (
    .clk     (clk),
    .rd_en   (adv),
    .rd_addr (k1),
    .wr_en   (tbl_wr_en),
    .wr_sel  (tbl_sel),
    .wr_addr (tbl_addr),
    .wr_data (tbl_data),
    .rd_data (coef2)
  );

  dpd_sq_rom #(.FW(FRC_W)) u_sq (
    .clk  (clk),
    .en   (adv),
    .addr (d1),
    .sq   (dsq2)
  );

  always_ff @(posedge clk) begin
    if (adv) begin
      d2 <= d1;
      x2 <= x1;
    end
  end

  // stage 3: Taylor refinement
  cplx_t gain_c, gain3, x3;
  dpd_gain_refine #(.FW(FRC_W)) u_ref (
    .g0      (coef2[0]),
    .g1      (coef2[1]),
    .g2      (coef2[2]),
    .frac    (d2),
    .frac_sq (dsq2),
    .gain    (gain_c)
  );

  always_ff @(posedge clk) begin
    if (adv) begin
      gain3 <= gain_c;
      x3    <= x2;
    end
  end

  // stage 4: apply gain
  cplx_t y_c, y4;
  dpd_cmul #(.FB(GAIN_FB)) u_mul (
    .x (x3),
    .g (gain3),
    .y (y_c)
  );

  always_ff @(posedge clk) begin
    if (adv) y4 <= y_c;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0; v4 <= 1'b0;
    end else if (adv) begin
      v1 <= in_valid; v2 <= v1; v3 <= v2; v4 <= v3;
    end
  end

  assign out_valid = v4;
  assign out_i     = y4.re;
  assign out_q     = y4.im;
endmodule

// File: rtl/dpd_taylor_lut_chk.sv
module dpd_taylor_lut_chk
  import dpd_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic signed [SMP_W-1:0] out_i,
  input logic signed [SMP_W-1:0] out_q
);
  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  a_r1_empty_after_reset: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_i) && $stable(out_q)));

  a_r8_block_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r9_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd5 && $past(in_valid && in_ready, 4) &&
     $past(out_ready, 3) && $past(out_ready, 2) && $past(out_ready, 1)) |-> out_valid);

  a_r7_known_output: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown({out_i, out_q}));
endmodule

bind dpd_taylor_lut dpd_taylor_lut_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_i     (out_i),
  .out_q     (out_q)
);

// File: tb/tb_dpd_taylor_lut.sv
`timescale 1ns/1ps
module tb_dpd_taylor_lut;
  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0, out_ready = 1;
  logic in_ready, out_valid;
  logic signed [15:0] in_i = 0, in_q = 0, out_i, out_q;
  logic tbl_wr_en = 0;
  logic [1:0] tbl_sel = 0;
  logic [5:0] tbl_addr = 0;
  logic [31:0] tbl_data = 0;

  always #10 clk = ~clk;  // 50 MHz

  dpd_taylor_lut dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q),
    .tbl_wr_en(tbl_wr_en), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr), .tbl_data(tbl_data)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int tre [3][64];
  int tim [3][64];
  int exp_re[$];
  int exp_im[$];

  task automatic check(input string req, input longint act, input longint expv, input string what);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int rnd(input longint v, input int sh);
    return sat16((v + (longint'(1) << (sh - 1))) >>> sh);
  endfunction

  function automatic void model(input int xi, input int xq, output int er, output int ei);
    longint p, x, d;
    int k, gr, gi;
    p = longint'(xi) * xi + longint'(xq) * xq;
    x = p >> 18;
    if (x > 4095) begin k = 63; d = 0; end      // R3
    else begin k = int'(x / 64); d = x % 64; end // R2
    gr = rnd(longint'(tre[0][k]) * 8192 + longint'(tre[1][k]) * d * 128 + longint'(tre[2][k]) * d * d, 13);
    gi = rnd(longint'(tim[0][k]) * 8192 + longint'(tim[1][k]) * d * 128 + longint'(tim[2][k]) * d * d, 13);
    er = rnd(longint'(xi) * gr - longint'(xq) * gi, 14);
    ei = rnd(longint'(xi) * gi + longint'(xq) * gr, 14);
  endfunction

  task automatic wr(input int sel, input int addr, input int re, input int im);
    @(negedge clk);
    tbl_wr_en = 1; tbl_sel = 2'(sel); tbl_addr = 6'(addr);
    tbl_data = {16'(re), 16'(im)};
    if (sel < 3) begin tre[sel][addr] = re; tim[sel][addr] = im; end
    @(negedge clk);
    tbl_wr_en = 0;
  endtask

  task automatic load_identity();
    for (int a = 0; a < 64; a++) begin
      wr(0, a, 16384, 0); wr(1, a, 0, 0); wr(2, a, 0, 0);
    end
  endtask

  task automatic load_random();
    for (int a = 0; a < 64; a++) begin
      wr(0, a, $urandom_range(12000, 20000), int'($urandom_range(0, 6000)) - 3000);
      wr(1, a, int'($urandom_range(0, 6000)) - 3000, int'($urandom_range(0, 6000)) - 3000);
      wr(2, a, int'($urandom_range(0, 6000)) - 3000, int'($urandom_range(0, 6000)) - 3000);
    end
  endtask

  function automatic int pick(input int lo, input int hi);
    int v = $urandom_range(lo, hi);
    if ($urandom_range(0, 1) == 1) v = -v;
    return v;
  endfunction

  task automatic traffic(input int n, input int lo, input int hi, input int rdy_pct, input string req);
    int sent = 0, got = 0;
    bit have = 0, hold = 0;
    int ci = 0, cq = 0, hi_v = 0, hq_v = 0, er, ei;
    while (got < n) begin
      @(negedge clk);
      if (hold) begin
        check("R8", out_valid, 1, "valid held during stall");
        check("R8", out_i, hi_v, "out_i held during stall");
        check("R8", out_q, hq_v, "out_q held during stall");
      end
      if (!have && sent < n) begin ci = pick(lo, hi); cq = pick(lo, hi); have = 1; end
      in_valid = have; in_i = 16'(ci); in_q = 16'(cq);
      out_ready = ($urandom_range(0, 99) < rdy_pct);
      #1;
      check("R8", in_ready, (!out_valid || out_ready), "in_ready rule");
      hold = out_valid && !out_ready; hi_v = out_i; hq_v = out_q;
      if (out_valid && out_ready) begin
        if (exp_re.size() == 0) check(req, 1, 0, "unexpected output");
        else begin
          check(req, out_i, exp_re.pop_front(), "out_i");
          check(req, out_q, exp_im.pop_front(), "out_q");
        end
        got++;
      end
      if (in_valid && in_ready) begin
        model(ci, cq, er, ei);
        exp_re.push_back(er); exp_im.push_back(ei);
        sent++; have = 0;
      end
    end
    @(negedge clk);
    in_valid = 0; out_ready = 1;
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    check("R1", out_valid, 0, "out_valid in reset");
    check("R1", in_ready, 1, "in_ready in reset");
    rst_n = 1;
    @(negedge clk);
    check("R1", out_valid, 0, "out_valid after reset");
    check("R1", in_ready, 1, "in_ready after reset");

    load_identity();
    // R9 latency with a single sample
    @(negedge clk);
    in_valid = 1; in_i = 16'sd1234; in_q = -16'sd4321; out_ready = 1;
    lat = 0;
    @(negedge clk); in_valid = 0; lat = 1;
    while (!out_valid && lat < 10) begin @(negedge clk); lat++; end
    check("R9", lat, 4, "latency in negedges");
    check("R7", out_i, 1234, "identity gain out_i");
    check("R7", out_q, -4321, "identity gain out_q");
    @(negedge clk);

    traffic(40, 0, 32767, 100, "R7");
    load_random();
    traffic(150, 0, 2000, 100, "R2");
    traffic(200, 0, 32767, 100, "R4");
    traffic(60, 30000, 32767, 100, "R3");
    traffic(200, 0, 32767, 50, "R8");

    // select 3 must leave every table untouched
    for (int a = 0; a < 64; a++) wr(3, a, 32767, -32768);
    traffic(60, 0, 32767, 100, "R5");
    // new entries used by the next samples
    for (int a = 0; a < 64; a++) wr(0, a, int'($urandom_range(0, 40000)) - 20000, 9000);
    traffic(60, 0, 32767, 100, "R6");

    check("R8", exp_re.size(), 0, "no outstanding samples");
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog run did not complete actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule